// File: doc/BRIEF.md
# Digital Input Interrupt Controller

This block watches a bank of digital input lines and turns activity on them into interrupts. Every line first passes through a multi-flop synchroniser. Software then chooses, line by line, whether that line may raise an interrupt at all. It also chooses whether the line triggers on a programmed level or on any change of state. A level-triggered line has its own polarity bit that picks the active level.

When a line's trigger condition is met, its bit in the pending register latches. Software clears a pending bit by writing a one to it. Writing a zero leaves the bit alone. A level condition that is still present sets the bit again on the next clock. Several events that arrive before service collapse into one pending bit.

A single interrupt output is asserted whenever any pending bit is set. All registers sit on a single-cycle word-addressed bus. The bus has an address, a write strobe, write data and combinational read data.

Top module: `dii_ctrl`

Register select (word address): 0 = synchronised input levels (read only), 1 = enable, 2 = mode, 3 = polarity, 4 = pending. Read data is zero-extended above the channel count.

## Requirements
- R1: Channel n is enabled, configured, reported and cleared through bit n of every per-channel register; other bits are unaffected.
- R2: With mode bit 0 (level), a polarity bit of 0 sets the pending bit while the synchronised input is 0, and a polarity bit of 1 sets it while the input is 1.
- R3: A channel whose enable bit is 0 never sets its pending bit, whatever its input does.
- R4: With mode bit 1 (change of state), both rising and falling transitions of the synchronised input set the pending bit. The polarity bit has no effect in this mode, and a steady input sets nothing.
- R5: Writing 1 to a pending bit (address 4) clears it; writing 0 leaves it unchanged.
- R6: A level-triggered channel whose condition persists sets its pending bit again on the clock after a clear, unless it has been disabled.
- R7: Reset clears the enable, mode, polarity and pending registers, and the interrupt output is low.
- R8: Several input events before service merge into one pending bit, and a single clear removes it.
- R9: When a set condition and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: The interrupt output is high exactly when at least one pending bit is 1.
- R11: Address 0 returns the input levels after the synchroniser (two register stages by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | N_CH | Asynchronous digital input lines |
| bus_addr_i | input | 3 | Word address of the register |
| bus_we_i | input | 1 | Write strobe for the addressed register |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Combinational read data of the addressed register |
| irq_o | output | 1 | Summary interrupt, high while anything is pending |

## Verification
The bench builds the block with N_CH = 8 and BUS_W = 16. At that size every channel bit is reachable, and the zero-extension of read data above the channel count can be observed. The synchroniser is kept at its default depth of two. With that depth, the cycle in which a change-of-state set coincides with a write-1 clear can be placed exactly, which exercises the set-over-clear rule.

// File: rtl/dii_pkg.sv
package dii_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_LEVELS   = 3'd0,
        SEL_ENABLE   = 3'd1,
        SEL_MODE     = 3'd2,
        SEL_POLARITY = 3'd3,
        SEL_PENDING  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/dii_sync.sv
module dii_sync #(
    parameter int N_CH   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] raw_i,
    output logic [N_CH-1:0] sync_o
);

    logic [N_CH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/dii_detect.sv
module dii_detect #(
    parameter int N_CH = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] level_i,
    input  logic [N_CH-1:0] enable_i,
    input  logic [N_CH-1:0] mode_i,
    input  logic [N_CH-1:0] polarity_i,
    output logic [N_CH-1:0] set_o
);

    logic [N_CH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        logic edge_hit;
        logic level_hit;
        assign edge_hit  = level_i[c] ^ prev_q[c];
        assign level_hit = ~(level_i[c] ^ polarity_i[c]);
        assign set_o[c]  = enable_i[c] & (mode_i[c] ? edge_hit : level_hit);
    end

endmodule

// File: rtl/dii_regs.sv
module dii_regs
    import dii_pkg::*;
#(
    parameter int N_CH  = 32,
    parameter int BUS_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic                  we_i,
    input  logic [BUS_W-1:0]      wdata_i,
    input  logic [N_CH-1:0]       level_i,
    input  logic [N_CH-1:0]       set_i,
    output logic [N_CH-1:0]       enable_o,
    output logic [N_CH-1:0]       mode_o,
    output logic [N_CH-1:0]       polarity_o,
    output logic [N_CH-1:0]       pending_o,
    output logic [N_CH-1:0]       clear_o,
    output logic [BUS_W-1:0]      rdata_o
);

    logic [N_CH-1:0] wbits;
    reg_sel_e        sel;

    assign wbits = wdata_i[N_CH-1:0];
    assign sel   = reg_sel_e'(addr_i);
    assign clear_o = (we_i && sel == SEL_PENDING) ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_o   <= '0;
            mode_o     <= '0;
            polarity_o <= '0;
        end else if (we_i) begin
            case (sel)
                SEL_ENABLE:   enable_o   <= wbits;
                SEL_MODE:     mode_o     <= wbits;
                SEL_POLARITY: polarity_o <= wbits;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pending_o <= '0;
        else     pending_o <= (pending_o & ~clear_o) | set_i;
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_LEVELS:   rdata_o = BUS_W'(level_i);
            SEL_ENABLE:   rdata_o = BUS_W'(enable_o);
            SEL_MODE:     rdata_o = BUS_W'(mode_o);
            SEL_POLARITY: rdata_o = BUS_W'(polarity_o);
            SEL_PENDING:  rdata_o = BUS_W'(pending_o);
            default:      rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/dii_ctrl.sv
module dii_ctrl
    import dii_pkg::*;
#(
    parameter int N_CH        = 32,
    parameter int BUS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_CH-1:0]       pins_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic                  bus_we_i,
    input  logic [BUS_W-1:0]      bus_wdata_i,
    output logic [BUS_W-1:0]      bus_rdata_o,
    output logic                  irq_o
);

    logic [N_CH-1:0] level;
    logic [N_CH-1:0] enable;
    logic [N_CH-1:0] mode;
    logic [N_CH-1:0] polarity;
    logic [N_CH-1:0] pending;
    logic [N_CH-1:0] clear;
    logic [N_CH-1:0] set_vec;

    dii_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pins_i),
        .sync_o (level)
    );

    dii_detect #(.N_CH(N_CH)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .level_i    (level),
        .enable_i   (enable),
        .mode_i     (mode),
        .polarity_i (polarity),
        .set_o      (set_vec)
    );

    dii_regs #(.N_CH(N_CH), .BUS_W(BUS_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (bus_addr_i),
        .we_i       (bus_we_i),
        .wdata_i    (bus_wdata_i),
        .level_i    (level),
        .set_i      (set_vec),
        .enable_o   (enable),
        .mode_o     (mode),
        .polarity_o (polarity),
        .pending_o  (pending),
        .clear_o    (clear),
        .rdata_o    (bus_rdata_o)
    );

    assign irq_o = |pending;

    // R3: a pending bit only rises on a channel that was enabled
    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending) & ~$past(enable)) == '0));

    // R2: a met level condition is pending one clock later
    a_r2_level_sets: assert property (@(posedge clk) disable iff (rst)
        (($past(enable & ~mode & ~(level ^ polarity)) & ~pending) == '0));

    // R4: any input transition on an enabled edge channel is pending
    a_r4_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (($past(enable & mode) & ($past(level) ^ $past(level, 2)) & ~pending) == '0));

    // R5: a pending bit not written with 1 stays set
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (($past(pending & ~clear) & ~pending) == '0));

    // R9: set and clear together leave the bit set
    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (($past(set_vec & clear) & ~pending) == '0));

endmodule

// File: tb/tb_dii_ctrl.sv
module tb_dii_ctrl;

    localparam int N_CH  = 8;
    localparam int BUS_W = 16;

    localparam logic [2:0] A_LEV = 3'd0;
    localparam logic [2:0] A_EN  = 3'd1;
    localparam logic [2:0] A_MOD = 3'd2;
    localparam logic [2:0] A_POL = 3'd3;
    localparam logic [2:0] A_PND = 3'd4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N_CH-1:0]  pins = '0;
    logic [2:0]       addr = '0;
    logic             we = 1'b0;
    logic [BUS_W-1:0] wdata = '0;
    logic [BUS_W-1:0] rdata;
    logic             irq;
    logic             rd_req = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [BUS_W-1:0] exp_q[$];
    string            tag_q[$];

    always #2 clk = ~clk;

    dii_ctrl #(.N_CH(N_CH), .BUS_W(BUS_W), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst         (rst),
        .pins_i      (pins),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input bit ok, input string req, input logic [BUS_W-1:0] act,
                         input logic [BUS_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with read data
    always @(negedge clk) begin
        if (rd_req && exp_q.size() > 0) begin
            logic [BUS_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata == e, t, rdata, e);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [BUS_W-1:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [BUS_W-1:0] e,
                             input string req);
        @(posedge clk); #1;
        addr = a;
        exp_q.push_back(e);
        tag_q.push_back(req);
        rd_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic irq_expect(input logic e, input string req);
        @(negedge clk);
        check(irq == e, req, BUS_W'(irq), BUS_W'(e));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R7 reset state
        rd_expect(A_EN,  16'h0000, "R7 enable after reset");
        rd_expect(A_MOD, 16'h0000, "R7 mode after reset");
        rd_expect(A_POL, 16'h0000, "R7 polarity after reset");
        rd_expect(A_PND, 16'h0000, "R7 pending after reset");
        irq_expect(1'b0, "R7 irq after reset");

        // R11 synchronised levels, zero-extended
        pins = 8'hA5;
        idle(3);
        rd_expect(A_LEV, 16'h00A5, "R11 levels A5");
        pins = 8'h3C;
        idle(3);
        rd_expect(A_LEV, 16'h003C, "R11 levels 3C");
        pins = 8'h00;
        idle(3);

        // R2/R1 level low on channel 0 with polarity 0; others disabled (R3)
        wr(A_EN, 16'h0001);
        idle(2);
        rd_expect(A_PND, 16'h0001, "R2 R1 R3 level-low channel 0 only");
        irq_expect(1'b1, "R10 irq with pending");

        // R5 write 0 keeps, R6 level re-sets
        wr(A_PND, 16'hFFFE);
        rd_expect(A_PND, 16'h0001, "R5 zero write keeps bit");
        wr(A_PND, 16'h0001);
        rd_expect(A_PND, 16'h0001, "R6 persisting level re-sets");
        wr(A_EN, 16'h0000);
        wr(A_PND, 16'h0001);
        rd_expect(A_PND, 16'h0000, "R6 R5 disabled then cleared");
        irq_expect(1'b0, "R10 irq low when none pending");

        // R2 polarity 1 on channel 2
        wr(A_POL, 16'h0004);
        wr(A_EN, 16'h0004);
        idle(3);
        rd_expect(A_PND, 16'h0000, "R2 pol1 input low no set");
        pins = 8'h04;
        idle(4);
        rd_expect(A_PND, 16'h0004, "R2 R1 pol1 input high sets bit 2");
        wr(A_EN, 16'h0000);
        wr(A_PND, 16'h0004);
        rd_expect(A_PND, 16'h0000, "R5 clear bit 2");

        // R3 disabled channels see activity
        pins = 8'hF0; idle(3);
        pins = 8'h0F; idle(3);
        pins = 8'h00; idle(3);
        rd_expect(A_PND, 16'h0000, "R3 disabled channels never set");

        // R4 change of state on channel 7, polarity set but ignored
        wr(A_MOD, 16'h0080);
        wr(A_POL, 16'h0080);
        wr(A_EN, 16'h0080);
        idle(3);
        rd_expect(A_PND, 16'h0000, "R4 steady input no set");
        pins = 8'h80;
        idle(4);
        rd_expect(A_PND, 16'h0080, "R4 rising edge sets");
        wr(A_PND, 16'h0080);
        idle(2);
        rd_expect(A_PND, 16'h0000, "R4 polarity ignored, stays clear");
        pins = 8'h00;
        idle(4);
        rd_expect(A_PND, 16'h0080, "R4 falling edge sets");
        wr(A_PND, 16'h0080);
        idle(2);

        // R8 several events merge
        pins = 8'h80; idle(4);
        pins = 8'h00; idle(4);
        pins = 8'h80; idle(4);
        rd_expect(A_PND, 16'h0080, "R8 merged events one bit");
        wr(A_PND, 16'h0080);
        idle(2);
        rd_expect(A_PND, 16'h0000, "R8 single clear removes all");

        // R9 edge-set coincides with a clear of the same bit
        @(posedge clk); #1;
        pins = 8'h00;
        @(posedge clk);
        @(posedge clk); #1;
        addr = A_PND; wdata = 16'h0080; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
        rd_expect(A_PND, 16'h0080, "R9 set wins over clear");
        wr(A_PND, 16'h0080);
        rd_expect(A_PND, 16'h0000, "R9 later clear works");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule